// File: doc/BRIEF.md
# Grouped-Priority Interrupt Preemption Controller

This block decides which exception the core enters next, and when. It watches up to sixteen peripheral interrupt lines and three system exception lines. It holds a pending flag per line and picks one winner from the pending set. It then decides whether that winner may interrupt the handler that is running now. When the winner is accepted, the block emits a one-cycle take strobe with the exception number. The core reports the end of each handler on a return input.

Every peripheral line has a 4-bit programmable priority. A global split setting divides that value into two fields. The upper field is the group, and only the group decides preemption. The lower field is the subpriority, and it only orders requests that are waiting. The three system exceptions sit above every programmable value. A small stack of active execution levels tracks nested handlers, so that each return restores the level that was interrupted.

Software programs the block through a simple write port. The same port can also raise a pending flag directly.

Top module: `irq_preempt_ctrl`

## Requirements
- R1: After reset, take_o is low, exec_level_o is 31 (idle), stack_err_o is low, no line is pending, every priority is 0 and the split is 0.
- R2: A line becomes pending on the clock edge that sees its input high after it was low, or on a write to address 17 whose wr_data_i[4:0] names an IRQ below 16. A line that stays high is not made pending again. The pending flag clears on the edge that accepts the request.
- R3: take_o is high for exactly the one cycle that follows the edge that accepts a request, which is two edges after the input edge. take_num_o then carries the exception number: 1, 2 and 3 for system lines 0, 1 and 2, and 16+n for IRQ n. exec_level_o shows the taken level in that same cycle.
- R4: A pending system line always wins over any IRQ. Line 0 has level 0 and beats line 1 (level 1), which beats line 2 (level 2).
- R5: Among pending IRQs, the one with the numerically lowest full 4-bit priority is taken first. This orders by group, then by subpriority. On a full tie, the lowest IRQ number wins.
- R6: A write to address 16 sets the split from wr_data_i[2:0]. This is the count of low subpriority bits, and values above 4 act as 4. The execution level of an IRQ is 3 plus its priority with the subpriority bits cleared.
- R7: The winner is accepted only if its level is strictly lower than the current execution level. A request whose group equals the running group, whatever its number or subpriority, stays pending.
- R8: exc_ret_i pops the top stack entry. No request is accepted in a cycle with exc_ret_i high. After the pop, a pending request that outranks the restored level is taken.
- R9: The stack holds 4 levels. A winner that would preempt while 4 levels are active is not taken and stays pending. stack_err_o rises one cycle later and stays high until reset.
- R10: A write to address n (n below 16) sets the priority of IRQ n to wr_data_i[3:0]. The new value takes effect from the next cycle.
- R11: exc_ret_i while the stack is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sys_req_i | input | 3 | System exception request lines, line 0 most urgent |
| irq_i | input | 16 | Peripheral interrupt request lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write address: 0-15 priority, 16 split, 17 set-pending |
| wr_data_i | input | 8 | Write data |
| exc_ret_i | input | 1 | Handler completion pulse from the core |
| take_o | output | 1 | One-cycle strobe: enter the exception on take_num_o |
| take_num_o | output | 6 | Number of the exception being taken |
| exec_level_o | output | 5 | Current execution level, 31 when idle |
| stack_err_o | output | 1 | Sticky flag: preemption attempted with the stack full |

## Verification
Each result has a fixed timing. A pending flag is set on the edge that sees a line rise. The take strobe and the new execution level appear after the following edge. A pop is visible one edge after the return pulse. The overflow flag rises one edge after the blocked attempt. The bench keeps a behavioural model that steps on the same rising edge as the design. Inputs change only on falling edges. Every output is compared 5 ns after each rising edge, so the model and the design are always compared for the same cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SYS_N    = 3;
  localparam int IRQ_BASE = 16;
  localparam int SPLIT_W  = 3;
  localparam int SETP_W   = 5;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_SPLIT,
    SEL_SETPEND
  } reg_sel_e;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q, pend_q, set_now;

  assign set_now = (req_i & ~req_q) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= (pend_q & ~clr_i) | set_now;  // a new set wins over a clear
    end
  end

  assign pend_o = pend_q;

  a_r2_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_now) != '0) |=> ((pend_o & $past(clr_i & ~set_now)) == '0));
  a_r2_edge_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_now != '0) |=> ((pend_o & $past(set_now)) == $past(set_now)));
endmodule

// File: rtl/irq_arb.sv
module irq_arb import irq_pkg::*; #(
  parameter int N_IRQ  = 16,
  parameter int PRIO_W = 4,
  parameter int LVL_W  = 5,
  parameter int EXC_W  = 6,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic [SYS_N-1:0]   sys_pend_i,
  input  logic [N_IRQ-1:0]   irq_pend_i,
  input  logic [PRIO_W-1:0]  prio_i [N_IRQ],
  input  logic [SPLIT_W-1:0] split_i,
  output logic               win_valid_o,
  output logic               win_sys_o,
  output logic [IDX_W-1:0]   win_idx_o,
  output logic [EXC_W-1:0]   win_num_o,
  output logic [LVL_W-1:0]   win_lvl_o
);
  logic [SPLIT_W-1:0] sub_bits;
  logic [PRIO_W-1:0]  gmask, best;
  logic [IDX_W-1:0]   bidx;
  logic               found;

  assign sub_bits = (int'(split_i) > PRIO_W) ? SPLIT_W'(PRIO_W) : split_i;
  assign gmask    = {PRIO_W{1'b1}} << sub_bits;

  always_comb begin
    found = 1'b0;
    best  = '1;
    bidx  = '0;
    // descending scan with <= leaves the lowest index on a tie
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (irq_pend_i[i] && (!found || prio_i[i] <= best)) begin
        found = 1'b1;
        best  = prio_i[i];
        bidx  = IDX_W'(i);
      end
    end
    win_valid_o = found;
    win_sys_o   = 1'b0;
    win_idx_o   = bidx;
    win_num_o   = EXC_W'(IRQ_BASE) + EXC_W'(bidx);
    win_lvl_o   = found ? LVL_W'(SYS_N) + LVL_W'(best & gmask) : '1;
    for (int s = SYS_N - 1; s >= 0; s--) begin
      if (sys_pend_i[s]) begin
        win_valid_o = 1'b1;
        win_sys_o   = 1'b1;
        win_idx_o   = IDX_W'(s);
        win_num_o   = EXC_W'(s + 1);
        win_lvl_o   = LVL_W'(s);
      end
    end
  end
endmodule

// File: rtl/irq_stack.sv
module irq_stack #(
  parameter int DEPTH = 4,
  parameter int LVL_W = 5,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic             pop_i,
  output logic [LVL_W-1:0] top_lvl_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [LVL_W-1:0] ent_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (push_i) begin
      cnt_q <= cnt_q + 1'b1;
      for (int i = 0; i < DEPTH; i++)
        if (cnt_q == CNT_W'(i)) ent_q[i] <= push_lvl_i;
    end else if (pop_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    top_lvl_o = '1;
    for (int i = 0; i < DEPTH; i++)
      if (cnt_q == CNT_W'(i + 1)) top_lvl_o = ent_q[i];
  end

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  a_r7_strict_nesting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !empty_o) |-> (push_lvl_i < top_lvl_o));
  a_r8_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (!empty_o && !push_i));
  a_r3_push_on_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (top_lvl_o == $past(push_lvl_i)));
endmodule

// File: rtl/irq_preempt_ctrl.sv
module irq_preempt_ctrl import irq_pkg::*; #(
  parameter int N_IRQ  = 16,
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(N_IRQ + 2),
  localparam int LVL_W  = $clog2(SYS_N + (1 << PRIO_W) + 1),
  localparam int EXC_W  = $clog2(IRQ_BASE + N_IRQ + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SYS_N-1:0]  sys_req_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              exc_ret_i,
  output logic              take_o,
  output logic [EXC_W-1:0]  take_num_o,
  output logic [LVL_W-1:0]  exec_level_o,
  output logic              stack_err_o
);
  localparam int IDX_W = $clog2(N_IRQ);

  reg_sel_e           sel;
  logic [PRIO_W-1:0]  prio_q [N_IRQ];
  logic [SPLIT_W-1:0] split_q;
  logic [N_IRQ-1:0]   sw_set, irq_clr, irq_pend;
  logic [SYS_N-1:0]   sys_clr, sys_pend;
  logic               win_valid, win_sys;
  logic [IDX_W-1:0]   win_idx;
  logic [EXC_W-1:0]   win_num;
  logic [LVL_W-1:0]   win_lvl, top_lvl;
  logic               st_full, st_empty, wants, accept, blocked, pop;
  logic               take_q, err_q;
  logic [EXC_W-1:0]   num_q;

  always_comb begin
    sel = SEL_NONE;
    if (wr_en_i) begin
      if (int'(wr_addr_i) < N_IRQ)       sel = SEL_PRIO;
      else if (int'(wr_addr_i) == N_IRQ) sel = SEL_SPLIT;
      else if (int'(wr_addr_i) == N_IRQ + 1) sel = SEL_SETPEND;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      split_q <= '0;
      for (int i = 0; i < N_IRQ; i++) prio_q[i] <= '0;
    end else begin
      if (sel == SEL_SPLIT) split_q <= wr_data_i[SPLIT_W-1:0];
      for (int i = 0; i < N_IRQ; i++)
        if (sel == SEL_PRIO && wr_addr_i == ADDR_W'(i)) prio_q[i] <= wr_data_i[PRIO_W-1:0];
    end
  end

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq_ctl
    assign sw_set[g]  = (sel == SEL_SETPEND) && (wr_data_i[SETP_W-1:0] == SETP_W'(g));
    assign irq_clr[g] = accept && !win_sys && (win_idx == IDX_W'(g));
  end
  for (genvar s = 0; s < SYS_N; s++) begin : g_sys_ctl
    assign sys_clr[s] = accept && win_sys && (win_idx == IDX_W'(s));
  end

  irq_pend #(.N(SYS_N)) u_sys_pend (
    .clk_i, .rst_ni, .req_i(sys_req_i), .set_i('0), .clr_i(sys_clr), .pend_o(sys_pend)
  );
  irq_pend #(.N(N_IRQ)) u_irq_pend (
    .clk_i, .rst_ni, .req_i(irq_i), .set_i(sw_set), .clr_i(irq_clr), .pend_o(irq_pend)
  );

  irq_arb #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .LVL_W(LVL_W), .EXC_W(EXC_W)) u_arb (
    .sys_pend_i(sys_pend), .irq_pend_i(irq_pend), .prio_i(prio_q), .split_i(split_q),
    .win_valid_o(win_valid), .win_sys_o(win_sys), .win_idx_o(win_idx),
    .win_num_o(win_num), .win_lvl_o(win_lvl)
  );

  // a return cycle never accepts, so the comparison always uses a settled top
  assign wants   = win_valid && (win_lvl < top_lvl) && !exc_ret_i;
  assign accept  = wants && !st_full;
  assign blocked = wants && st_full;
  assign pop     = exc_ret_i && !st_empty;

  irq_stack #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_stack (
    .clk_i, .rst_ni, .push_i(accept), .push_lvl_i(win_lvl), .pop_i(pop),
    .top_lvl_o(top_lvl), .full_o(st_full), .empty_o(st_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      num_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      take_q <= accept;
      if (accept) num_q <= win_num;
      if (blocked) err_q <= 1'b1;
    end
  end

  assign take_o       = take_q;
  assign take_num_o   = num_q;
  assign exec_level_o = top_lvl;
  assign stack_err_o  = err_q;

  a_r3_take_nonidle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (exec_level_o != '1));
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_err_o |=> stack_err_o);
  a_r5_winner_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid && !win_sys) |-> irq_pend[win_idx]);
  a_r4_sys_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_pend != '0) |-> (win_valid && win_sys));
endmodule

// File: tb/irq_preempt_ctrl_test.sv
module irq_preempt_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sys_req = '0;
  logic [15:0] irq = '0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       exc_ret = 1'b0;
  logic       take;
  logic [5:0] take_num;
  logic [4:0] exec_level;
  logic       stack_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  irq_preempt_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .sys_req_i(sys_req), .irq_i(irq),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .exc_ret_i(exc_ret),
    .take_o(take), .take_num_o(take_num), .exec_level_o(exec_level), .stack_err_o(stack_err)
  );

  // behavioural reference
  int m_prio[16];
  int m_split;
  bit m_ipend[16], m_prev_irq[16];
  bit m_spend[3], m_prev_sys[3];
  int m_stack[$];
  bit m_err, exp_take;
  int exp_num;

  function automatic int cur_level();
    return (m_stack.size() == 0) ? 31 : m_stack[$];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_prio[i]) begin m_prio[i] = 0; m_ipend[i] = 0; m_prev_irq[i] = 0; end
      foreach (m_spend[i]) begin m_spend[i] = 0; m_prev_sys[i] = 0; end
      m_split = 0; m_stack.delete(); m_err = 0; exp_take = 0; exp_num = 0;
    end else begin
      bit wv, ws, acc;
      int wi, wl, wn, best, sb;
      wv = 0; ws = 0; wi = 0; wl = 31; wn = 0;
      for (int s = 0; s < 3; s++)
        if (m_spend[s] && !wv) begin wv = 1; ws = 1; wi = s; wl = s; wn = s + 1; end
      if (!wv) begin
        best = 99;
        for (int i = 0; i < 16; i++)
          if (m_ipend[i] && m_prio[i] < best) begin best = m_prio[i]; wi = i; wv = 1; end
        if (wv) begin
          sb = (m_split > 4) ? 4 : m_split;
          wl = 3 + ((best >> sb) << sb);
          wn = 16 + wi;
        end
      end
      acc = wv && (wl < cur_level()) && !exc_ret && (m_stack.size() < 4);
      if (wv && (wl < cur_level()) && !exc_ret && m_stack.size() == 4) m_err = 1;
      exp_take = acc;
      if (acc) begin
        exp_num = wn;
        if (ws) m_spend[wi] = 0; else m_ipend[wi] = 0;
        m_stack.push_back(wl);
      end
      if (exc_ret && m_stack.size() > 0) void'(m_stack.pop_back());
      for (int i = 0; i < 16; i++) begin
        if (irq[i] && !m_prev_irq[i]) m_ipend[i] = 1;
        m_prev_irq[i] = irq[i];
      end
      for (int s = 0; s < 3; s++) begin
        if (sys_req[s] && !m_prev_sys[s]) m_spend[s] = 1;
        m_prev_sys[s] = sys_req[s];
      end
      if (wr_en) begin
        if (wr_addr < 16) m_prio[wr_addr] = wr_data & 15;
        else if (wr_addr == 16) m_split = wr_data & 7;
        else if (wr_addr == 17 && (wr_data & 31) < 16) m_ipend[wr_data & 31] = 1;
      end
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    #5;
    if (!done) begin
      check("take_o", take, exp_take);
      if (exp_take) check("take_num_o", take_num, exp_num);
      check("exec_level_o", exec_level, cur_level());
      check("stack_err_o", stack_err, m_err);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; wr_addr = 5'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(int n);
    @(negedge clk); irq[n] = 1;
    @(negedge clk); irq[n] = 0;
  endtask

  task automatic ret();
    @(negedge clk); exc_ret = 1;
    @(negedge clk); exc_ret = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    idle(3); rst_n = 1; idle(3);

    cur_req = "R10";
    wr(3, 5); wr(9, 2);
    cur_req = "R3";
    pulse(3); idle(4); ret(); idle(2);

    cur_req = "R2";
    @(negedge clk); irq[9] = 1; idle(5); ret(); idle(5); irq[9] = 0; idle(2);
    wr(17, 7); idle(3); ret(); wr(17, 20); idle(3);

    cur_req = "R11";
    ret(); ret(); idle(2);

    cur_req = "R5";
    wr(1, 6); wr(2, 6); wr(4, 8);
    @(negedge clk); irq[1] = 1; irq[2] = 1; irq[4] = 1;
    @(negedge clk); irq = '0;
    idle(3); ret(); idle(3); ret(); idle(3); ret(); idle(3);

    cur_req = "R6";
    wr(16, 2); wr(5, 6); wr(6, 4);
    pulse(5); idle(3);
    cur_req = "R7";
    pulse(6); idle(4);
    cur_req = "R8";
    ret(); idle(4); ret(); idle(2);
    wr(16, 7); wr(5, 12); wr(6, 3); pulse(5); idle(2); pulse(6); idle(3); ret(); ret(); idle(3);

    cur_req = "R4";
    wr(16, 0); pulse(3); idle(2);
    @(negedge clk); sys_req = 3'b111;
    @(negedge clk); sys_req = '0;
    idle(4); ret(); idle(2); ret(); idle(2); ret(); idle(2); ret(); idle(3);

    cur_req = "R9";
    wr(10, 15); wr(11, 12); wr(12, 8); wr(13, 4);
    pulse(10); idle(2); pulse(11); idle(2); pulse(12); idle(2); pulse(13); idle(2);
    @(negedge clk); sys_req[2] = 1; @(negedge clk); sys_req[2] = 0;
    idle(4); ret(); idle(3);
    repeat (5) begin ret(); idle(2); end

    cur_req = "R8 R7 R5";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      irq = 16'($urandom) & 16'($urandom) & 16'($urandom);
      sys_req = (($urandom % 40) == 0) ? 3'($urandom) : 3'b000;
      exc_ret = (($urandom % 3) == 0);
      wr_en = (($urandom % 6) == 0);
      wr_addr = 5'($urandom % 18);
      wr_data = 8'($urandom);
    end
    @(negedge clk); irq = '0; sys_req = '0; exc_ret = 0; wr_en = 0;
    idle(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule